// File: doc/BRIEF.md
# Serial EEPROM Block Reader

This block is a two-wire bus master that fetches a run of consecutive bytes from a serial EEPROM, starting at word address zero. A host pulses `go` with a byte count. The master then sets the device's internal address with a dummy write and turns the bus around with a repeated start. After that it clocks the requested bytes out of the memory one after another. Each byte arrives on `rd_data` together with a one-cycle `rd_valid` strobe. A single-cycle `done` marks the end of the transaction, and `err` reports whether it failed.

The block drives the two bus lines through open-drain control outputs with inverted sense: a control bit at 1 pulls its line low, and a 0 lets the pull-up raise it. The data line is read back without inversion. A slave can be left holding the data line low, for example after an interrupted transfer. To free it, the master checks the line before every start condition and, if it is low, issues a limited burst of clock pulses. A failed stop condition is retried a limited number of times. All bus timing is built from one half-period of `CLKS_PER_HALF` system clocks.

Top module: `eeprom_seq_reader`

## Requirements
- R1: During and after reset, `scl_ctl`, `sda_ctl`, `rd_valid`, `done` and `err` are all 0, so both bus lines are released.
- R2: A control output at 1 pulls its line low and at 0 releases it; `sda_in` is taken as the true line level (low = 0).
- R3: A successful transaction on the bus is: start, byte 0xA0, slave ACK, byte 0x00, slave ACK, repeated start, byte 0xA1, slave ACK, the reads, then one stop. That makes exactly two start conditions and one stop. When `done` is high, both control outputs are 0.
- R4: Bytes go most significant bit first in both directions, and byte k delivered on `rd_data` equals the memory content at address k.
- R5: `sda_ctl` never changes in the same cycle as `scl_ctl`. A clock pulse is three half-periods: SCL low with the previous data, SCL low with the new data, then SCL released.
- R6: The master ACKs every received byte except the last one, which it NACKs before the stop. With a count of 0, the stop follows straight after the ACK of 0xA1, and no byte is strobed.
- R7: Before each start, if SDA reads low, the master releases SDA and gives up to 10 clock pulses. It samples SDA at the end of each pulse and stops pulsing once it reads high. If SDA is still low after the 10th pulse, the transaction ends with `done` and `err` and no start condition.
- R8: After each byte it sends, the master releases SDA for one clock pulse. If SDA reads high at the end of that pulse, the transaction ends at once with `done` and `err`, and no stop.
- R9: A stop drives SDA low for one pulse, then releases SDA with SCL high and samples it one half-period later. A low level causes a retry. After 10 failed attempts the transaction ends with `err`.
- R10: `rd_valid` and `done` are single-cycle pulses. `err` holds its value after `done` until the next accepted `go`, which clears it in that same cycle.
- R11: `go` is ignored while a transaction is in progress; the count latched at the start is kept.
- R12: The probe before a start, the start hold and the stop release each last one half-period, and each clock pulse lasts three. `done` rises on the clock edge that closes the last of these.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a transaction (accepted only when idle) |
| nbytes | input | CNT_W | Number of bytes to read |
| sda_in | input | 1 | Sensed SDA line level |
| scl_ctl | output | 1 | SCL control, 1 pulls the line low |
| sda_ctl | output | 1 | SDA control, 1 pulls the line low |
| rd_valid | output | 1 | One-cycle strobe for a received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Failure flag, held until the next go |

## Verification
Each segment lasts `CLKS_PER_HALF` cycles, so `done` is due a fixed number of cycles after the edge that accepts `go`. That number is the count of half-periods the bus sequence uses times `CLKS_PER_HALF`. A model slave holds its ACK until SCL falls, so every repeated start costs one recovery pulse; the expected count includes it. The bench counts rising edges from the accepting edge and samples on the falling edge, so the count must match exactly. A byte strobe is sampled on the falling edge after the edge that closes its eighth high phase. `err` is checked a few cycles after `done` to confirm it holds.

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader #(
  parameter int CLKS_PER_HALF = 250,
  parameter int CNT_W         = 8,
  parameter int RETRY_MAX     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             sda_in,
  output logic             scl_ctl,
  output logic             sda_ctl,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err
);

  localparam int DW = $clog2(CLKS_PER_HALF + 1);
  localparam int TW = $clog2(RETRY_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_RCV, S_START, S_TX, S_RX, S_STOP, S_REL
  } st_t;

  st_t             st;
  logic [DW-1:0]   div;
  logic [1:0]      seg;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic [1:0]      ph;
  logic [TW-1:0]   tries;
  logic [CNT_W-1:0] left;
  logic            pulse_sda;

  wire tick      = (div == DW'(CLKS_PER_HALF - 1));
  wire ack_slot  = bitn[3];
  wire last      = (left == CNT_W'(1));
  wire in_pulse  = (st == S_RCV) || (st == S_TX) || (st == S_RX) || (st == S_STOP);
  wire pulse_end = tick && (seg == 2'd2);
  wire out_of_tries = (tries == TW'(RETRY_MAX - 1));

  always_comb begin
    case (st)
      S_TX:    pulse_sda = ack_slot ? 1'b0 : ~sh[7];
      S_RX:    pulse_sda = ack_slot & ~last;
      S_STOP:  pulse_sda = 1'b1;
      default: pulse_sda = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      seg      <= '0;
      bitn     <= '0;
      sh       <= '0;
      ph       <= '0;
      tries    <= '0;
      left     <= '0;
      scl_ctl  <= 1'b0;
      sda_ctl  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      div      <= (st == S_IDLE || tick) ? '0 : div + 1'b1;

      if (in_pulse && tick) begin
        case (seg)
          2'd0: begin seg <= 2'd1; sda_ctl <= pulse_sda; end
          2'd1: begin seg <= 2'd2; scl_ctl <= 1'b0; end
          default: begin seg <= 2'd0; scl_ctl <= 1'b1; end
        endcase
      end

      case (st)
        S_IDLE: begin
          scl_ctl <= 1'b0;
          sda_ctl <= 1'b0;
          if (go) begin
            st   <= S_PROBE;
            err  <= 1'b0;
            left <= nbytes;
            ph   <= 2'd0;
          end
        end

        S_PROBE: if (tick) begin
          if (sda_in) begin
            st      <= S_START;
            sda_ctl <= 1'b1;
          end else begin
            st      <= S_RCV;
            tries   <= '0;
            seg     <= 2'd0;
            scl_ctl <= 1'b1;
          end
        end

        S_RCV: if (pulse_end) begin
          if (sda_in) begin
            st      <= S_START;
            scl_ctl <= 1'b0;
            sda_ctl <= 1'b1;
          end else if (out_of_tries) begin
            st      <= S_IDLE;
            scl_ctl <= 1'b0;
            done    <= 1'b1;
            err     <= 1'b1;
          end else begin
            tries <= tries + 1'b1;
          end
        end

        S_START: if (tick) begin
          st      <= S_TX;
          seg     <= 2'd0;
          bitn    <= '0;
          scl_ctl <= 1'b1;
          sh      <= (ph == 2'd2) ? 8'hA1 : 8'hA0;
        end

        S_TX: if (pulse_end) begin
          if (!ack_slot) begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 1'b1;
          end else if (sda_in) begin
            st      <= S_IDLE;
            scl_ctl <= 1'b0;
            done    <= 1'b1;
            err     <= 1'b1;
          end else begin
            bitn <= '0;
            case (ph)
              2'd0: begin ph <= 2'd1; sh <= 8'h00; end
              2'd1: begin ph <= 2'd2; st <= S_PROBE; scl_ctl <= 1'b0; end
              default: begin
                tries <= '0;
                st    <= (left == '0) ? S_STOP : S_RX;
              end
            endcase
          end
        end

        S_RX: if (pulse_end) begin
          if (!ack_slot) begin
            sh   <= {sh[6:0], sda_in};
            bitn <= bitn + 1'b1;
            if (bitn == 4'd7) begin
              rd_valid <= 1'b1;
              rd_data  <= {sh[6:0], sda_in};
            end
          end else begin
            left <= left - 1'b1;
            bitn <= '0;
            if (last) begin
              st    <= S_STOP;
              tries <= '0;
            end
          end
        end

        S_STOP: if (pulse_end) begin
          st      <= S_REL;
          scl_ctl <= 1'b0;
          sda_ctl <= 1'b0;
        end

        S_REL: if (tick) begin
          if (sda_in) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (out_of_tries) begin
            st   <= S_IDLE;
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            tries   <= tries + 1'b1;
            st      <= S_STOP;
            scl_ctl <= 1'b1;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic scl_ctl,
  input logic sda_ctl,
  input logic rd_valid,
  input logic done,
  input logic err
);

  // R5
  sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_ctl) |-> $stable(sda_ctl));

  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  valid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(go));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R3
  bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_ctl && !sda_ctl));

  // R6
  valid_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !done);

endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .scl_ctl(scl_ctl), .sda_ctl(sda_ctl),
  .rd_valid(rd_valid), .done(done), .err(err)
);

// File: tb/eeprom_seq_reader_test.sv
module eeprom_seq_reader_test;

  localparam int HALF = 4;
  localparam int CW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [CW-1:0] nbytes = '0;
  logic          scl_ctl, sda_ctl, rd_valid, done, err;
  logic [7:0]    rd_data;

  always #10 clk = ~clk;

  // model slave state (one process owns it)
  logic s_rst = 1'b0;
  int   cfg_hold = 0, cfg_nack = 0, cfg_sblk = 0;
  logic slv_rel = 1'b1;
  int   hold = 0;
  int   smode = 0, bitc = 0, nrx = 0, ptr = 0, sblk = 0;
  int   starts = 0, stops = 0, pre_pulses = 0, macks = 0, mnacks = 0;
  logic [7:0] rsh = '0, tsh = '0;
  logic [7:0] logb [0:3];
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  wire scl_line = ~scl_ctl;
  wire sda_line = ~sda_ctl & slv_rel & (hold == 0);

  eeprom_seq_reader #(.CLKS_PER_HALF(HALF), .CNT_W(CW), .RETRY_MAX(10)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .nbytes(nbytes), .sda_in(sda_line),
    .scl_ctl(scl_ctl), .sda_ctl(sda_ctl), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err(err)
  );

  function automatic logic [7:0] memv(input int k);
    return 8'((k * 29 + 155) % 256);
  endfunction

  always @(scl_line or sda_line or s_rst) begin
    if (s_rst) begin
      slv_rel = 1'b1; hold = cfg_hold; smode = 0; bitc = 0; nrx = 0; ptr = 0;
      sblk = cfg_sblk; starts = 0; stops = 0; pre_pulses = 0; macks = 0; mnacks = 0;
      for (int i = 0; i < 4; i++) logb[i] = 8'hxx;
    end else if (scl_line && prev_scl) begin
      if (prev_sda && !sda_line) begin
        starts++; smode = 1; bitc = 0;
      end else if (!prev_sda && sda_line) begin
        if (starts > 0) stops++;
        smode = 0;
      end
    end else if (scl_line && !prev_scl) begin
      if (starts == 0) pre_pulses++;
      if (hold > 0) hold--;
      if (smode == 1) begin
        if (bitc < 8) begin
          rsh = {rsh[6:0], sda_line}; bitc++;
        end else begin
          if (nrx < 4) logb[nrx] = rsh;
          nrx++; bitc = 0;
          if (slv_rel) smode = 0;
          else if (rsh == 8'hA1) begin smode = 2; tsh = memv(ptr); end
          else if (nrx == 2) ptr = int'(rsh);
        end
      end else if (smode == 2) begin
        if (bitc < 8) bitc++;
        else if (!sda_line) begin macks++; ptr++; tsh = memv(ptr); bitc = 0; end
        else begin mnacks++; smode = 3; end
      end else if (smode == 3) begin
        if (sblk > 0) begin slv_rel = 1'b0; sblk--; end
      end
    end else if (!scl_line && prev_scl) begin
      if (smode == 1) slv_rel = (bitc == 8) ? ((nrx + 1 == cfg_nack) ? 1'b1 : 1'b0) : 1'b1;
      else if (smode == 2) slv_rel = (bitc < 8) ? tsh[7 - bitc] : 1'b1;
      else slv_rel = 1'b1;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // received byte monitor
  int nvalid = 0, bad = 0;
  always @(negedge clk) begin
    if (s_rst) begin
      nvalid = 0; bad = 0;
    end else if (rd_valid) begin
      if (rd_data !== memv(nvalid)) bad++;
      nvalid++;
    end
  end

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input int stuck, input int nk, input int sb, input bit poke);
    int  halves, pre, cyc, exp_starts, exp_stops, reads;
    bit  exp_err, seen;
    exp_err    = (stuck > 10) || (nk != 0) || (sb >= 10);
    pre        = 1 + 3 * stuck;
    if (stuck > 10)   halves = 31;
    else if (nk == 1) halves = pre + 28;
    else if (nk == 2) halves = pre + 55;
    else if (nk == 3) halves = pre + 87;
    else              halves = pre + 87 + 27 * n + ((sb >= 10) ? 40 : 4 * (sb + 1));
    exp_starts = (stuck > 10) ? 0 : ((nk == 1 || nk == 2) ? 1 : 2);
    exp_stops  = (stuck <= 10 && nk == 0 && sb < 10) ? 1 : 0;
    reads      = (stuck <= 10 && nk == 0) ? n : 0;

    cfg_hold = stuck; cfg_nack = nk; cfg_sblk = sb;
    @(negedge clk); s_rst = 1'b1;
    @(negedge clk); @(negedge clk); s_rst = 1'b0;
    @(negedge clk);
    nbytes = CW'(n); go = 1'b1;
    @(posedge clk);
    @(negedge clk); go = 1'b0;
    chk(err == 1'b0, "R10 err cleared by go", int'(err), 0);
    cyc = 0; seen = 1'b0;
    while (!seen && cyc < 20000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (poke && cyc == 60) begin go = 1'b1; nbytes = CW'(n + 3); end
      else go = 1'b0;
      if (done) seen = 1'b1;
    end
    go = 1'b0;
    chk(seen, "watchdog done", cyc, halves * HALF);
    chk(cyc == halves * HALF, poke ? "R11 busy go ignored, R12 done timing" : "R12 done timing", cyc, halves * HALF);
    chk(err == exp_err, nk != 0 ? "R8 err on nack" : (stuck > 10 ? "R7 err on stuck" : "R9 err on stop"), int'(err), int'(exp_err));
    chk(starts == exp_starts, "R3 start count", starts, exp_starts);
    chk(stops == exp_stops, "R3 R9 stop count", stops, exp_stops);
    chk(pre_pulses == ((stuck > 10) ? 10 : stuck), "R7 recovery pulses", pre_pulses, (stuck > 10) ? 10 : stuck);
    chk(nvalid == reads, "R6 strobe count", nvalid, reads);
    chk(bad == 0, "R4 byte values", bad, 0);
    if (exp_starts == 2) begin
      chk(logb[0] == 8'hA0, "R2 R3 device write byte", int'(logb[0]), 'hA0);
      chk(logb[1] == 8'h00, "R3 address byte", int'(logb[1]), 0);
      chk(logb[2] == 8'hA1, "R3 device read byte", int'(logb[2]), 'hA1);
    end
    if (reads > 0) begin
      chk(macks == reads - 1, "R6 master acks", macks, reads - 1);
      chk(mnacks == 1, "R6 final nack", mnacks, 1);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    @(negedge clk); @(negedge clk);
    chk(err == exp_err, "R10 err held", int'(err), int'(exp_err));
    chk(!scl_ctl && !sda_ctl, "R3 bus released", int'({scl_ctl, sda_ctl}), 0);
  endtask

  initial begin
    s_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_ctl && !sda_ctl && !done && !err && !rd_valid, "R1 reset outputs",
        int'({scl_ctl, sda_ctl, done, err, rd_valid}), 0);
    rst_n = 1'b1;
    s_rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_ctl && !sda_ctl && !done && !err, "R1 idle outputs",
        int'({scl_ctl, sda_ctl, done, err}), 0);
    chk(scl_line && sda_line, "R2 lines high when released", int'({scl_line, sda_line}), 3);

    for (int n = 0; n <= 6; n++) run(n, 0, 0, 0, 1'b0);
    run(16, 0, 0, 0, 1'b0);
    for (int s = 1; s <= 11; s++) run(2, s, 0, 0, 1'b0);
    for (int k = 1; k <= 3; k++) run(3, 0, k, 0, 1'b0);
    run(2, 0, 0, 1, 1'b0);
    run(2, 0, 0, 9, 1'b0);
    run(2, 0, 0, 10, 1'b0);
    run(4, 0, 0, 0, 1'b1);
    run(1, 0, 0, 0, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule